// File: doc/BRIEF.md
# Low-Power Domain Register Write Bridge

This block carries register writes from a fast bus clock into a slow always-on domain clocked at about 32.768 kHz. Each write to a slow-side register or to the status register is one transaction. The bridge captures the address and data and hands a toggle request across two-flop synchronizers. The slow side counts out a fixed settle time, commits the value and returns a toggle acknowledge. While the transaction is in flight, the bus side shows that it is busy and refuses further synchronized writes.

Progress is visible in a status word and on one interrupt line. The busy flag (bit 10) is set while a transaction is in flight. The next flag (bit 9) is set whenever a new write would be taken. The complete flag (bit 8) is sticky and is cleared by reading the status register. The error flag (bit 7) marks a write that arrived too early and was dropped. Clearing the error flag is itself a synchronized write, so it takes effect only when that write completes. The interrupt-enable register sits entirely in the bus clock domain and takes effect on the next cycle.

Address map for `NREG` slow registers: addresses 0 to NREG-1 are the slow registers, address NREG is the status register, address NREG+1 is the interrupt-enable register, and any higher address is unmapped.

Top module: `lpw_write_bridge`

## Requirements
- R1: After reset the status register reads 0x200 (only the next flag), the interrupt-enable register reads 0, every slow register reads 0, and `irq` is low.
- R2: A write to a slow register or to the status register while idle is accepted. From the next bus cycle until completion, status bit 10 (busy) is 1 and bit 9 (next) is 0.
- R3: An accepted slow-register write updates that register on the LP_CYCLES-th rising edge of `lp_clk` after the accepting bus edge. A later read of the same address returns the written value.
- R4: Completion becomes visible on the third rising bus edge after the slow-side commit. On that edge busy clears and status bit 8 (complete) sets.
- R5: A read of the status register (`rd_en` with address NREG) returns the value before the clear and clears bit 8 on that edge. If completion falls on the same edge, bit 8 stays set.
- R6: A write to a slow register or to the status register while busy sets status bit 7 (error) on that edge. The write is discarded: no register changes, and the running transaction is not affected.
- R7: Writing the status register with bit 7 set starts a synchronized transaction. The error flag stays set while that transaction is busy and clears on the edge where it completes. An error raised on that same edge wins over the clear.
- R8: A write to address NREG+1 loads data bits 9, 8 and 7 into the next, complete and error enables on that edge. This happens even while busy, and the write leaves busy and the complete flag unchanged.
- R9: `irq` is high exactly when at least one of these holds: next is set with its enable, complete is set with its enable, or error is set with its enable.
- R10: Writes to addresses above NREG+1 have no effect, and reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset, bus domain |
| lp_clk | input | 1 | Slow low-power domain clock |
| lp_rst_n | input | 1 | Synchronous active-low reset, slow domain |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| rd_en | input | 1 | Read strobe (carries the read side effect on the status register) |
| addr | input | AW | Register address, AW = clog2(NREG+2) |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench builds the block with its defaults: NREG = 4, LP_CYCLES = 4 and DW = 32. With these values the address field is three bits wide, which leaves addresses 6 and 7 unmapped, so R10 can be exercised. The bench runs the slow clock at one eighth of the bus rate with its edges offset from the bus edges. This makes every transaction settle within a few dozen bus cycles and keeps the synchronizer latency deterministic. Under those conditions the reference model can predict the exact edge on which busy clears. It also makes reachable the case where a status read lands on the same edge as completion.

// File: rtl/lpw_pkg.sv
// Shared bit positions and flag type for the low-power write bridge.
// Assumes a data width of at least 11 bits so the status field fits.
package lpw_pkg;
    localparam int ST_BUSY = 10;
    localparam int ST_NEXT = 9;
    localparam int ST_DONE = 8;
    localparam int ST_ERR  = 7;

    // Interrupt-enable group, ordered to match status bits 9..7
    typedef struct packed {
        logic nxt;
        logic cmp;
        logic err;
    } lpw_irq_t;
endpackage

// File: rtl/lpw_sync2.sv
// Two-flop synchronizer for W independent level signals.
// Assumes each bit changes at most once per several destination clocks.
module lpw_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture the asynchronous input, then re-time it once more
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/lpw_bus_ctrl.sv
// Bus-side control of the bridge: accepts or rejects writes, launches the
// toggle request, detects the returning acknowledge, and keeps the status
// flags and the interrupt enables. Assumes a single-cycle wr_en/rd_en strobe
// and that the transaction payload stays stable until the acknowledge returns.
module lpw_bus_ctrl
    import lpw_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NREG = 4,
    parameter int AW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          ack_tgl,
    output logic          req_tgl,
    output logic [AW-1:0] txn_addr,
    output logic [DW-1:0] txn_data,
    output logic          busy,
    output logic          wcf,
    output logic          wef,
    output lpw_irq_t      ien,
    output logic          done
);
    localparam logic [AW-1:0] STAT_A = AW'(NREG);
    localparam logic [AW-1:0] IEN_A  = AW'(NREG + 1);

    logic ack_s;
    logic ack_seen;
    logic sync_hit;
    logic accept;
    logic reject;
    logic clr_err;

    lpw_sync2 #(.W(1)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tgl),
        .q     (ack_s)
    );

    // Classify the current write and detect completion
    always_comb begin
        sync_hit = wr_en && ((addr < STAT_A) || (addr == STAT_A));
        accept   = sync_hit && !busy;
        reject   = sync_hit && busy;
        done     = ack_s != ack_seen;
        clr_err  = done && (txn_addr == STAT_A) && txn_data[ST_ERR];
    end

    // Launch a transaction: flip the request and hold the payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_tgl  <= 1'b0;
            txn_addr <= '0;
            txn_data <= '0;
        end else if (accept) begin
            req_tgl  <= ~req_tgl;
            txn_addr <= addr;
            txn_data <= wdata;
        end
    end

    // Track the acknowledge toggle already consumed
    always_ff @(posedge clk) begin
        if (!rst_n) ack_seen <= 1'b0;
        else        ack_seen <= ack_s;
    end

    // Busy from acceptance until the acknowledge edge
    always_ff @(posedge clk) begin
        if (!rst_n)      busy <= 1'b0;
        else if (accept) busy <= 1'b1;
        else if (done)   busy <= 1'b0;
    end

    // Complete flag: set on completion, cleared by a status read
    always_ff @(posedge clk) begin
        if (!rst_n)                         wcf <= 1'b0;
        else if (done)                      wcf <= 1'b1;
        else if (rd_en && addr == STAT_A)   wcf <= 1'b0;
    end

    // Error flag: set by an early write, cleared by a completed clear request
    always_ff @(posedge clk) begin
        if (!rst_n)       wef <= 1'b0;
        else if (reject)  wef <= 1'b1;
        else if (clr_err) wef <= 1'b0;
    end

    // Interrupt enables live in the bus domain and load directly
    always_ff @(posedge clk) begin
        if (!rst_n)                     ien <= '0;
        else if (wr_en && addr == IEN_A) ien <= lpw_irq_t'(wdata[ST_NEXT:ST_ERR]);
    end
endmodule

// File: rtl/lpw_lp_side.sv
// Slow-domain half of the bridge: synchronizes the request toggle, waits a
// fixed number of slow cycles, commits the payload into the register file and
// returns an acknowledge toggle. Assumes LP_CYCLES >= 3 (two are spent in the
// synchronizer) and that the payload is stable while a request is pending.
module lpw_lp_side #(
    parameter int DW        = 32,
    parameter int NREG      = 4,
    parameter int AW        = 3,
    parameter int LP_CYCLES = 4
) (
    input  logic          lp_clk,
    input  logic          lp_rst_n,
    input  logic          req_tgl,
    input  logic [AW-1:0] txn_addr,
    input  logic [DW-1:0] txn_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          ack_tgl
);
    localparam int HOLD = LP_CYCLES - 2;
    localparam int CW   = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic          req_s;
    logic          req_seen;
    logic          pend;
    logic          fire;
    logic [CW-1:0] cnt;
    logic [DW-1:0] regs [NREG];

    lpw_sync2 #(.W(1)) u_req_sync (
        .clk   (lp_clk),
        .rst_n (lp_rst_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    // A new request is pending until its commit edge
    always_comb begin
        pend = req_s != req_seen;
        fire = pend && (cnt == LAST);
    end

    // Settle counter for the pending request
    always_ff @(posedge lp_clk) begin
        if (!lp_rst_n)  cnt <= '0;
        else if (fire)  cnt <= '0;
        else if (pend)  cnt <= cnt + 1'b1;
    end

    // Consume the request and answer with an acknowledge toggle
    always_ff @(posedge lp_clk) begin
        if (!lp_rst_n) begin
            req_seen <= 1'b0;
            ack_tgl  <= 1'b0;
        end else if (fire) begin
            req_seen <= req_s;
            ack_tgl  <= ~ack_tgl;
        end
    end

    // One register per slot, written on the commit edge
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge lp_clk) begin
            if (!lp_rst_n)                            regs[i] <= '0;
            else if (fire && txn_addr == AW'(i))      regs[i] <= txn_data;
        end
    end

    // Read selection; out-of-range addresses return zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == AW'(i)) rd_data = regs[i];
        end
    end
endmodule

// File: rtl/lpw_write_bridge.sv
// Top of the low-power write bridge. Joins the bus-side control and the
// slow-domain register file, builds the status word, the read mux and the
// interrupt. Assumes DW >= 11 and NREG >= 1.
module lpw_write_bridge
    import lpw_pkg::*;
#(
    parameter int DW        = 32,
    parameter int NREG      = 4,
    parameter int LP_CYCLES = 4,
    localparam int AW       = $clog2(NREG + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lp_clk,
    input  logic          lp_rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq
);
    localparam logic [AW-1:0] STAT_A = AW'(NREG);
    localparam logic [AW-1:0] IEN_A  = AW'(NREG + 1);

    logic          req_tgl;
    logic          ack_tgl;
    logic [AW-1:0] txn_addr;
    logic [DW-1:0] txn_data;
    logic          busy;
    logic          wcf;
    logic          wef;
    logic          done;
    lpw_irq_t      ien;
    logic [DW-1:0] reg_rd;
    logic [DW-1:0] status;
    logic [DW-1:0] ien_word;

    lpw_bus_ctrl #(.DW(DW), .NREG(NREG), .AW(AW)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .ack_tgl  (ack_tgl),
        .req_tgl  (req_tgl),
        .txn_addr (txn_addr),
        .txn_data (txn_data),
        .busy     (busy),
        .wcf      (wcf),
        .wef      (wef),
        .ien      (ien),
        .done     (done)
    );

    lpw_lp_side #(.DW(DW), .NREG(NREG), .AW(AW), .LP_CYCLES(LP_CYCLES)) u_lp (
        .lp_clk   (lp_clk),
        .lp_rst_n (lp_rst_n),
        .req_tgl  (req_tgl),
        .txn_addr (txn_addr),
        .txn_data (txn_data),
        .rd_addr  (addr),
        .rd_data  (reg_rd),
        .ack_tgl  (ack_tgl)
    );

    // Assemble the status and enable words at their bit positions
    always_comb begin
        status           = '0;
        status[ST_BUSY]  = busy;
        status[ST_NEXT]  = ~busy;
        status[ST_DONE]  = wcf;
        status[ST_ERR]   = wef;
        ien_word         = '0;
        ien_word[ST_NEXT:ST_ERR] = ien;
    end

    // Read mux over slow registers, status and enables
    always_comb begin
        if (addr < STAT_A)       rdata = reg_rd;
        else if (addr == STAT_A) rdata = status;
        else if (addr == IEN_A)  rdata = ien_word;
        else                     rdata = '0;
    end

    // Interrupt: each flag gated by its own enable
    always_comb begin
        irq = (ien.nxt & ~busy) | (ien.cmp & wcf) | (ien.err & wef);
    end
endmodule

// File: rtl/lpw_checker.sv
// Protocol checks for the bridge, attached to every instance by bind.
// Assumes the port names of lpw_write_bridge and its internal flag names.
module lpw_checker #(
    parameter int NREG = 4,
    parameter int AW   = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [AW-1:0] addr,
    input logic          busy,
    input logic          wcf,
    input logic          wef,
    input logic          done,
    input logic          ien_nxt,
    input logic          irq
);
    localparam logic [AW-1:0] STAT_A = AW'(NREG);
    localparam logic [AW-1:0] IEN_A  = AW'(NREG + 1);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && addr < STAT_A) |=> busy);

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R4
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (wcf && !busy));

    // R5
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == STAT_A && !done) |=> !wcf);

    // R6
    early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy && (addr < STAT_A || addr == STAT_A)) |=> wef);

    // R8
    ien_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == IEN_A && !busy) |=> !busy);

    // R9
    irq_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ien_nxt) |-> irq);
endmodule

bind lpw_write_bridge lpw_checker #(.NREG(NREG), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .busy    (busy),
    .wcf     (wcf),
    .wef     (wef),
    .done    (done),
    .ien_nxt (ien.nxt),
    .irq     (irq)
);

// File: tb/lpw_write_bridge_test.sv
// Bench for lpw_write_bridge: behavioural reference model compared every
// bus cycle, plus directed checks per requirement.
module lpw_write_bridge_test;
    localparam int NREG = 4;
    localparam int STA  = 4;
    localparam int IEA  = 5;

    logic        clk = 1'b0;
    logic        lp_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lp_rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    lpw_write_bridge uut (
        .clk(clk), .rst_n(rst_n), .lp_clk(lp_clk), .lp_rst_n(lp_rst_n),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    // 50 MHz bus clock; slow clock at 1/8 rate, edges offset by 5 ns
    always #10 clk = ~clk;
    initial begin
        #5;
        forever #80 lp_clk = ~lp_clk;
    end

    // ---------------- reference model ----------------
    bit          m_busy, m_wcf, m_wef;
    bit [2:0]    m_ien;
    bit [31:0]   m_reg [NREG];
    int          phase, lp_cnt, bus_cnt;
    int          p_addr;
    bit [31:0]   p_data;

    always @(posedge clk) begin
        bit ob, dn;
        if (!rst_n) begin
            m_busy = 0; m_wcf = 0; m_wef = 0; m_ien = 0; phase = 0;
        end else begin
            ob = m_busy; dn = 0;
            if (phase == 2) begin
                bus_cnt++;
                if (bus_cnt == 3) begin dn = 1; phase = 0; end
            end
            if (rd_en && addr == STA) m_wcf = 0;
            if (dn) begin
                m_busy = 0; m_wcf = 1;
                if (p_addr == STA && p_data[7]) m_wef = 0;
            end
            if (wr_en) begin
                if (addr <= STA) begin
                    if (ob) m_wef = 1;
                    else begin
                        m_busy = 1; p_addr = addr; p_data = wdata;
                        phase = 1; lp_cnt = 0;
                    end
                end else if (addr == IEA) m_ien = wdata[9:7];
            end
        end
    end

    always @(posedge lp_clk) begin
        if (!lp_rst_n) begin
            for (int i = 0; i < NREG; i++) m_reg[i] = 0;
        end else if (phase == 1) begin
            lp_cnt++;
            if (lp_cnt == 4) begin
                if (p_addr < NREG) m_reg[p_addr] = p_data;
                phase = 2; bus_cnt = 0;
            end
        end
    end

    function automatic bit [31:0] model_rd(int a);
        bit [31:0] v = 0;
        if (a < NREG) v = m_reg[a];
        else if (a == STA) begin
            v[10] = m_busy; v[9] = !m_busy; v[8] = m_wcf; v[7] = m_wef;
        end else if (a == IEA) v[9:7] = m_ien;
        return v;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // Per-cycle comparison, 5 ns before the next bus edge
    always @(negedge clk) begin
        #5;
        if (rst_n && !ended) begin
            if (addr < NREG)      chk("R3 model reg",  rdata, model_rd(addr));
            else if (addr == STA) chk("R4 model stat", rdata, model_rd(addr));
            else if (addr == IEA) chk("R8 model ien",  rdata, model_rd(addr));
            else                  chk("R10 model gap", rdata, model_rd(addr));
            chk("R9 model irq", {31'd0, irq},
                {31'd0, (!m_busy & m_ien[2]) | (m_wcf & m_ien[1]) | (m_wef & m_ien[0])});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(int a, bit [31:0] d);
        @(negedge clk); wr_en = 1; addr = 3'(a); wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic peek(int a, output logic [31:0] v);
        @(negedge clk); addr = 3'(a); rd_en = 0;
        #5 v = rdata;
    endtask

    task automatic rd_status(output logic [31:0] v);
        @(negedge clk); addr = 3'(STA); rd_en = 1;
        #5 v = rdata;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 300; i++) begin
            peek(STA, v);
            if (!v[10]) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int seen;
        repeat (20) @(negedge clk);
        rst_n = 1; lp_rst_n = 1;

        // R1 reset state
        peek(STA, v); chk("R1 status", v, 32'h200);
        peek(IEA, v); chk("R1 ien", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        peek(0, v);   chk("R1 reg0", v, 0);

        // R2 R3 R4 basic write
        wr(1, 32'hA5A5_1234);
        peek(STA, v); chk("R2 busy", v, 32'h400);
        wait_idle();
        peek(STA, v); chk("R4 complete", v, 32'h300);
        peek(1, v);   chk("R3 reg1", v, 32'hA5A5_1234);

        // R5 read clears complete
        rd_status(v); chk("R5 pre-clear value", v, 32'h300);
        peek(STA, v); chk("R5 cleared", v, 32'h200);

        // R6 early write discarded
        wr(2, 32'h1111_1111);
        wr(3, 32'h2222_2222);
        peek(STA, v); chk("R6 error set", v, 32'h480);
        wait_idle();
        peek(3, v);   chk("R6 discarded", v, 0);
        peek(2, v);   chk("R3 reg2", v, 32'h1111_1111);
        peek(STA, v); chk("R6 flags after", v, 32'h380);

        // R7 error clear is synchronized
        wr(STA, 32'h80);
        peek(STA, v); chk("R7 error held while busy", v, 32'h580);
        wait_idle();
        peek(STA, v); chk("R7 error cleared", v, 32'h300);

        // R8 enable write during busy
        rd_status(v);
        wr(0, 32'hDEAD_BEEF);
        wr(IEA, 32'h100);
        peek(STA, v); chk("R8 busy kept", v, 32'h400);
        peek(IEA, v); chk("R8 ien loaded", v, 32'h100);
        chk("R9 irq low busy", {31'd0, irq}, 0);
        wait_idle();
        peek(STA, v); chk("R9 irq on complete", {31'd0, irq}, 1);
        rd_status(v);
        peek(STA, v); chk("R9 irq after clear", {31'd0, irq}, 0);

        // R9 next-flag interrupt
        wr(IEA, 32'h200);
        peek(STA, v); chk("R9 irq on next", {31'd0, irq}, 1);
        wr(0, 32'h5);
        peek(STA, v); chk("R9 irq off while busy", {31'd0, irq}, 0);
        wait_idle();
        peek(STA, v); chk("R9 irq back", {31'd0, irq}, 1);
        wr(IEA, 0);

        // R10 unmapped address
        wr(6, 32'hFFFF_FFFF);
        peek(STA, v); chk("R10 no busy", {31'd0, v[10]}, 0);
        peek(6, v);   chk("R10 read 6", v, 0);
        peek(7, v);   chk("R10 read 7", v, 0);

        // R5 read coinciding with completion
        rd_status(v);
        wr(1, 32'h0000_0007);
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk); addr = 3'(STA); rd_en = 1;
            #5;
            if (rdata[8]) seen++;
            if (!rdata[10] && !rdata[8]) break;
        end
        @(negedge clk); rd_en = 0;
        chk("R5 complete seen once", seen, 1);
        peek(1, v); chk("R3 reg1 again", v, 32'h7);

        repeat (4) @(negedge clk);
        ended = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule